// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block picks, for each of eight interrupt channels, one line out of a wide bank of GPIO pad interrupt inputs. It then conditions that line into an active-high request for a downstream interrupt controller. Each channel has a byte-wide pad selector. Each channel's trigger mode (level, single edge or both edges) and its polarity are packed as bit groups into one shared trigger register. A fourth register holds a 4-bit deglitch filter code per channel. The block only stores these codes; the filter itself is outside this block.

Software programs the block through a plain register port: byte address, 32-bit write data, a write strobe and combinational read data. Every write replaces a whole 32-bit word. To change one channel's field, software reads the word, modifies the field and writes the word back. Each channel output comes from a trigger conditioner instance. The conditioner keeps a one-cycle history of the selected pad, so an edge shows up as a single-cycle pulse. A level trigger passes the pad straight through, inverted when low polarity is set.

Top module: `gpio_irq_route`

## Requirements
- R1: After reset, all four registers read 0 and, with all pads at 0, all eight channel outputs are 0.
- R2: Word offsets 0x0 (trigger), 0x4 (selectors for channels 0-3), 0x8 (selectors for channels 4-7) and 0xC (filter codes, 4 bits per channel, channel n at bits 4n+3:4n) read back what was last written. A write becomes visible on the read port only after the clock edge on which the strobe is sampled.
- R3: A write to any other offset changes no register, and a read of any other offset returns 0.
- R4: Trigger register bits 31:24 are not stored and always read 0.
- R5: Channel n takes its selector from bits 8*(n mod 4)+7 : 8*(n mod 4) of offset 0x4 when n<4, and from offset 0x8 otherwise. When trigger bits n, 8+n and 16+n are all 0, output n equals the selected pad.
- R6: A selector value at or above the number of pads feeds a constant 0 into that channel.
- R7: With trigger bit 16+n set and bits n and 8+n clear (level low), output n is the inverse of the selected input.
- R8: With trigger bit n set and bits 16+n and 8+n clear (rising edge), output n is 1 for exactly the one cycle in which the selected input is 1 and its value at the previous clock edge was 0.
- R9: With trigger bits n and 16+n set and bit 8+n clear (falling edge), output n pulses for one cycle when the selected input goes from 1 to 0, and ignores rises.
- R10: Trigger bit 8+n (both edges) takes precedence over bits n and 16+n: output n pulses for one cycle on every change of the selected input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads | input | NUM_PADS | GPIO pad interrupt lines |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 8 | Active-high channel requests |

## Verification
The case that is hardest to reach is a selector that points past the end of the pad bank. It is unreachable with the default 256 pads, because a byte cannot exceed 255. The bench therefore builds the block with only 20 pads. This makes selector values 20 to 255 out of range, so they can be driven and combined with low polarity: a constant 0 that is then inverted must give a steady 1. Edge modes are checked one cycle at a time. Pads change only at the falling clock edge, so each pulse is observed just before the rising edge that clears it, and observed again just after.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CH_COUNT = 8;
  localparam int SEL_W    = 8;
  localparam int FILT_W   = 4;
  localparam int REG_W    = 32;
  localparam int TRIG_W   = 3 * CH_COUNT;

  localparam int OFF_TRIG = 'h0;
  localparam int OFF_SELA = 'h4;
  localparam int OFF_SELB = 'h8;
  localparam int OFF_FILT = 'hC;

  typedef enum logic [2:0] {
    TRG_LVL_HI,
    TRG_LVL_LO,
    TRG_RISE,
    TRG_FALL,
    TRG_ANY
  } trig_mode_e;

  // both-edge bit wins, then edge bit, then level
  function automatic trig_mode_e decode_mode(input logic edge_b, input logic low_b,
                                             input logic any_b);
    if (any_b)       return TRG_ANY;
    else if (edge_b) return low_b ? TRG_FALL : TRG_RISE;
    else             return low_b ? TRG_LVL_LO : TRG_LVL_HI;
  endfunction

  function automatic logic [SEL_W-1:0] pick_sel(input logic [REG_W-1:0] wa,
                                                input logic [REG_W-1:0] wb,
                                                input int ch);
    logic [REG_W-1:0] w;
    w = (ch < 4) ? wa : wb;
    return w[(ch % 4) * SEL_W +: SEL_W];
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [REG_W-1:0]                   wdata,
  input  logic                               we,
  output logic [REG_W-1:0]                   rdata,
  output logic [TRIG_W-1:0]                  trig_o,
  output logic [CH_COUNT-1:0][SEL_W-1:0]     sel_o
);

  logic [TRIG_W-1:0] trig_q;
  logic [REG_W-1:0]  sela_q, selb_q, filt_q;
  logic hit_trig, hit_sela, hit_selb, hit_filt, hit_any;

  assign hit_trig = (addr == ADDR_W'(OFF_TRIG));
  assign hit_sela = (addr == ADDR_W'(OFF_SELA));
  assign hit_selb = (addr == ADDR_W'(OFF_SELB));
  assign hit_filt = (addr == ADDR_W'(OFF_FILT));
  assign hit_any  = hit_trig | hit_sela | hit_selb | hit_filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      sela_q <= '0;
      selb_q <= '0;
      filt_q <= '0;
    end else if (we) begin
      if (hit_trig) trig_q <= wdata[TRIG_W-1:0];
      if (hit_sela) sela_q <= wdata;
      if (hit_selb) selb_q <= wdata;
      if (hit_filt) filt_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_trig) rdata = {{(REG_W-TRIG_W){1'b0}}, trig_q};
    if (hit_sela) rdata = sela_q;
    if (hit_selb) rdata = selb_q;
    if (hit_filt) rdata = filt_q;
  end

  assign trig_o = trig_q;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_sel
    assign sel_o[c] = pick_sel(sela_q, selb_q, c);
  end

  AST_UNDEF_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit_any) |=> ($stable(trig_q) && $stable(sela_q) && $stable(selb_q) && $stable(filt_q))); // R3
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_trig) |=> $stable(trig_q)); // R2

endmodule

// File: rtl/gpio_irq_padmux.sv
module gpio_irq_padmux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads,
  input  logic [SEL_W-1:0]    sel,
  output logic                pad_o
);

  localparam int IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic in_range;

  assign in_range = (int'(sel) < NUM_PADS);
  assign pad_o    = in_range ? pads[sel[IDX_W-1:0]] : 1'b0;

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NUM_PADS) |-> !pad_o); // R6

endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  input  logic edge_b,
  input  logic low_b,
  input  logic any_b,
  output logic irq_o
);

  trig_mode_e mode;
  logic       prev_q, rise_ev, fall_ev;

  assign mode    = decode_mode(edge_b, low_b, any_b);
  assign rise_ev = pad_i & ~prev_q;
  assign fall_ev = ~pad_i & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pad_i;
  end

  always_comb begin
    unique case (mode)
      TRG_LVL_HI: irq_o = pad_i;
      TRG_LVL_LO: irq_o = ~pad_i;
      TRG_RISE:   irq_o = rise_ev;
      TRG_FALL:   irq_o = fall_ev;
      TRG_ANY:    irq_o = rise_ev | fall_ev;
      default:    irq_o = 1'b0;
    endcase
  end

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_RISE && irq_o) |=> !(mode == TRG_RISE && irq_o)); // R8
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRG_FALL && irq_o) |=> !(mode == TRG_FALL && irq_o)); // R9

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS = 256,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  input  logic                bus_we,
  output logic [REG_W-1:0]    bus_rdata,
  output logic [CH_COUNT-1:0] irq_out
);

  logic [TRIG_W-1:0]              trig;
  logic [CH_COUNT-1:0][SEL_W-1:0] sel;
  logic [CH_COUNT-1:0]            ch_in;

  gpio_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .we    (bus_we),
    .rdata (bus_rdata),
    .trig_o(trig),
    .sel_o (sel)
  );

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    gpio_irq_padmux #(.NUM_PADS(NUM_PADS)) u_mux (
      .clk  (clk),
      .rst_n(rst_n),
      .pads (pads),
      .sel  (sel[c]),
      .pad_o(ch_in[c])
    );
    gpio_irq_trig u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .pad_i (ch_in[c]),
      .edge_b(trig[c]),
      .any_b (trig[CH_COUNT + c]),
      .low_b (trig[2*CH_COUNT + c]),
      .irq_o (irq_out[c])
    );
  end

endmodule

// File: tb/gpio_irq_route_tb.sv
module gpio_irq_route_tb;

  localparam int CLK_P = 10;
  localparam int NP    = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pads = '0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_route #(.NUM_PADS(NP), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pads(pads), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_pads(input logic [NP-1:0] p);
    @(negedge clk);
    pads = p;
    #1;
  endtask

  function automatic logic [31:0] put_byte(input logic [31:0] w, input int pos, input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[pos*8 +: 8] = b;
    return r;
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a += 4) rd_check("R1", 4'(a), 32'h0);
    #1; check("R1 irq", {24'h0, irq_out}, 32'h0);

    // R2 / R4: write visibility and readback
    @(negedge clk);
    bus_addr = 4'h4; bus_wdata = 32'hA5C3_3C5A; bus_we = 1'b1;
    #1; check("R2 before edge", bus_rdata, 32'h0);
    @(negedge clk); bus_we = 1'b0;
    rd_check("R2 sela", 4'h4, 32'hA5C3_3C5A);
    wr(4'h8, 32'h1234_5678); rd_check("R2 selb", 4'h8, 32'h1234_5678);
    wr(4'hC, 32'hFEDC_BA98); rd_check("R2 filt", 4'hC, 32'hFEDC_BA98);
    wr(4'h0, 32'hFFFF_FFFF); rd_check("R4 trig", 4'h0, 32'h00FF_FFFF);
    wr(4'h0, 32'h5A12_3456); rd_check("R4 trig", 4'h0, 32'h0012_3456);

    // R3: undefined offsets
    for (int a = 0; a < 16; a++) begin
      if ((a % 4) != 0) begin
        wr(4'(a), 32'hFFFF_FFFF);
        rd_check("R3 read", 4'(a), 32'h0);
      end
    end
    rd_check("R3 trig", 4'h0, 32'h0012_3456);
    rd_check("R3 sela", 4'h4, 32'hA5C3_3C5A);
    rd_check("R3 selb", 4'h8, 32'h1234_5678);
    rd_check("R3 filt", 4'hC, 32'hFEDC_BA98);

    // R5: selector sweep, level high
    wr(4'h0, 32'h0);
    for (int ch = 0; ch < 8; ch++) begin
      for (int s = 0; s < NP; s++) begin
        logic [31:0] wa, wb;
        wa = 32'hFFFF_FFFF; wb = 32'hFFFF_FFFF;
        if (ch < 4) wa = put_byte(wa, ch, 8'(s));
        else        wb = put_byte(wb, ch - 4, 8'(s));
        wr(4'h4, wa); wr(4'h8, wb);
        set_pads(NP'(1) << s);
        check("R5 hit", {24'h0, irq_out}, 32'(1) << ch);
        set_pads(~(NP'(1) << s));
        check("R5 miss", {24'h0, irq_out}, 32'h0);
      end
    end

    // R6: out-of-range selectors give 0, inverted by low polarity
    for (int k = 0; k < 4; k++) begin
      logic [7:0] sv;
      sv = (k == 0) ? 8'd20 : (k == 1) ? 8'd21 : (k == 2) ? 8'd100 : 8'd255;
      wr(4'h4, {4{sv}}); wr(4'h8, {4{sv}});
      wr(4'h0, 32'h0);
      set_pads('1);
      check("R6 zero", {24'h0, irq_out}, 32'h0);
      wr(4'h0, 32'(1) << (16 + k));
      #1; check("R6 low", {24'h0, irq_out}, 32'(1) << k);
    end

    // identity routing for the remaining checks
    wr(4'h4, 32'h0302_0100); wr(4'h8, 32'h0706_0504);

    // R7: level low
    wr(4'h0, 32'h00FF_0000);
    for (int k = 0; k < 4; k++) begin
      logic [NP-1:0] p;
      p = (k == 0) ? NP'('hA5) : (k == 1) ? NP'('h5A) : (k == 2) ? NP'('hFF) : NP'('h0);
      set_pads(p);
      check("R7", {24'h0, irq_out}, {24'h0, ~p[7:0]});
    end

    // R8: rising edge
    wr(4'h0, 32'h0000_00FF);
    set_pads('0); @(negedge clk);
    set_pads(NP'('hC3));
    check("R8 pulse", {24'h0, irq_out}, 32'hC3);
    @(negedge clk); #1;
    check("R8 end", {24'h0, irq_out}, 32'h0);
    set_pads('0);
    check("R8 fall ignored", {24'h0, irq_out}, 32'h0);

    // R9: falling edge
    wr(4'h0, 32'h00FF_00FF);
    set_pads(NP'('h3C)); @(negedge clk); #1;
    check("R9 rise ignored", {24'h0, irq_out}, 32'h0);
    set_pads(NP'('h0C));
    check("R9 pulse", {24'h0, irq_out}, 32'h30);
    @(negedge clk); #1;
    check("R9 end", {24'h0, irq_out}, 32'h0);

    // R10: both edges, with precedence over the other bits
    for (int k = 0; k < 2; k++) begin
      wr(4'h0, (k == 0) ? 32'h0000_FF00 : 32'h00FF_FFFF);
      set_pads('0); @(negedge clk);
      set_pads(NP'('h96));
      check("R10 rise", {24'h0, irq_out}, 32'h96);
      @(negedge clk); #1;
      check("R10 gap", {24'h0, irq_out}, 32'h0);
      set_pads(NP'('h06));
      check("R10 fall", {24'h0, irq_out}, 32'h90);
      @(negedge clk); #1;
      check("R10 end", {24'h0, irq_out}, 32'h0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule